// File: doc/BRIEF.md
# Byte-Stream Operand Prefetcher

This block sits between a 16-bit instruction memory port and an execution core that consumes a byte-coded instruction stream. It keeps up to four upcoming stream bytes in a staging buffer. It fetches one 16-bit half-word at a time whenever there is room for it. On request, it presents the next operand in the format the core asks for: a sign-extended byte, a zero-extended byte, a two-byte word, or a variable-length "big" operand that takes one or two bytes.

The core holds a request strobe together with a format code. The operand is returned combinationally in the first cycle in which the buffer holds enough bytes for that format's worst case. The bytes used are removed at that clock edge. Until then a stall flag is raised. A branch is taken through a flush input that carries a new byte address. The flush discards everything buffered and restarts fetching at that address. When the address is odd, the byte below it is dropped.

Top module: `opf_prefetch`

## Requirements
- R1: After reset the buffer is empty, `op_valid` and `stall` are low, `mem_req` is high and `mem_addr` is 0.
- R2: Format code 0 (signed byte) returns the next byte sign-extended to 16 bits and consumes one byte.
- R3: Format code 1 (unsigned byte) returns the next byte zero-extended to 16 bits and consumes one byte.
- R4: Format code 2 (word) returns the next two bytes as one value. The first stream byte is the low byte (bits 7:0) and the second is the high byte. Two bytes are consumed.
- R5: Format code 3 (big) with the first byte's bit 7 clear returns that byte's value (0..127) and consumes one byte.
- R6: Format code 3 with the first byte's bit 7 set returns ((first & 0x7F) << 8) | second (up to 32767) and consumes two bytes.
- R7: A request is served only when the buffer holds at least the worst-case byte count for its format: one byte for codes 0 and 1, two bytes for codes 2 and 3. This applies even when a big operand would turn out short. Until then `stall` is high and `op_valid` is low.
- R8: A flush empties the buffer and restarts fetching at the even half-word address containing `flush_addr`. `mem_addr` is always even. Memory half-words are little-endian: the byte at the even address is bits 7:0.
- R9: After a flush to an odd address, the first half-word fetched contributes only its high byte, so the stream resumes exactly at `flush_addr`.
- R10: A half-word is requested only while at least two of the four byte slots are free. The buffer never holds more than four bytes. Each accepted half-word advances `mem_addr` by 2.
- R11: A cycle with `mem_req` high and `mem_valid` low adds no bytes and leaves `mem_addr` unchanged.
- R12: In a cycle with `flush` high, `op_valid` and `mem_req` are low and no pending request is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | output | 1 | Half-word fetch request |
| mem_addr | output | ADDR_W | Even byte address of the requested half-word |
| mem_valid | input | 1 | Memory returns `mem_rdata` this cycle; with `mem_req` the half-word is taken |
| mem_rdata | input | 16 | Half-word read data, even-address byte in bits 7:0 |
| req_stb | input | 1 | Operand request, held until `op_valid` |
| req_fmt | input | 2 | Format code: 0 signed byte, 1 unsigned byte, 2 word, 3 big |
| flush | input | 1 | Discard buffer and redirect fetch |
| flush_addr | input | ADDR_W | Byte address of the new stream position |
| op_data | output | 16 | Formatted operand |
| op_valid | output | 1 | `op_data` is valid and its bytes are consumed at this edge |
| stall | output | 1 | A request is waiting for more bytes |

## Verification
Some properties are checked by assertions on every cycle. These are the occupancy bound, even fetch addresses, the two-byte step after each accepted half-word, an empty buffer after any flush, and the absence of fills while memory is not valid. Also checked every cycle: a word or big operand is never served from fewer than two bytes, and a short big operand equals its first byte. Other behaviour can only be shown by the bench's directed scenarios. This covers each format's value and byte consumption along a known stream, and the held stall of a short big request after an odd flush. It also covers the dropped low byte on an odd redirect, the fetch stopping once the buffer is full, and a flush winning over a pending request.

// File: rtl/opf_pkg.sv
package opf_pkg;
    typedef enum logic [1:0] {
        FMT_SBYTE = 2'd0,
        FMT_UBYTE = 2'd1,
        FMT_WORD  = 2'd2,
        FMT_BIG   = 2'd3
    } opf_fmt_e;
endpackage

// File: rtl/opf_format.sv
module opf_format
    import opf_pkg::*;
(
    input  logic [7:0]  byte0,
    input  logic [7:0]  byte1,
    input  opf_fmt_e    fmt,
    output logic [15:0] value,
    output logic [1:0]  used,
    output logic [1:0]  need
);
    always_comb begin
        value = '0;
        used  = 2'd1;
        need  = 2'd1;
        unique case (fmt)
            FMT_SBYTE: value = {{8{byte0[7]}}, byte0};
            FMT_UBYTE: value = {8'h00, byte0};
            FMT_WORD: begin
                value = {byte1, byte0};
                used  = 2'd2;
                need  = 2'd2;
            end
            FMT_BIG: begin
                need = 2'd2;
                if (byte0[7]) begin
                    value = {1'b0, byte0[6:0], byte1};
                    used  = 2'd2;
                end else begin
                    value = {8'h00, byte0};
                end
            end
            default: value = '0;
        endcase
    end
endmodule

// File: rtl/opf_fetch_ctl.sv
module opf_fetch_ctl #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [ADDR_W-1:0] flush_addr,
    input  logic              take,
    output logic [ADDR_W-1:0] addr_o,
    output logic              skip_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              skip;
    } fctl_t;

    fctl_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d.addr = {flush_addr[ADDR_W-1:1], 1'b0};
            s_d.skip = flush_addr[0];
        end else if (take) begin
            s_d.addr = s_q.addr + ADDR_W'(2);
            s_d.skip = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign addr_o = s_q.addr;
    assign skip_o = s_q.skip;

    // R10
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !flush) |=> (addr_o == $past(addr_o) + ADDR_W'(2)));

    // R11
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !flush) |=> (addr_o == $past(addr_o)));
endmodule

// File: rtl/opf_prefetch.sv
module opf_prefetch
    import opf_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BUF_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [15:0]       mem_rdata,
    input  logic              req_stb,
    input  logic [1:0]        req_fmt,
    input  logic              flush,
    input  logic [ADDR_W-1:0] flush_addr,
    output logic [15:0]       op_data,
    output logic              op_valid,
    output logic              stall
);
    localparam int CNT_W = $clog2(BUF_BYTES + 1);
    localparam int IDX_W = $clog2(BUF_BYTES);
    localparam logic [CNT_W-1:0] FILL_LIMIT = CNT_W'(BUF_BYTES - 2);

    typedef struct packed {
        logic [BUF_BYTES-1:0][7:0] slots;
        logic [CNT_W-1:0]          cnt;
    } pbuf_t;

    pbuf_t s_d, s_q;

    opf_fmt_e                  fmt;
    logic [15:0]               fmt_value;
    logic [1:0]                fmt_used;
    logic [1:0]                fmt_need;
    logic                      enough;
    logic                      take;
    logic                      skip;
    logic [1:0]                used_n;
    logic [BUF_BYTES-1:0][7:0] slots_sh;
    logic [CNT_W-1:0]          cnt_sh;
    logic [IDX_W-1:0]          wr0;
    logic [IDX_W-1:0]          wr1;

    assign fmt = opf_fmt_e'(req_fmt);

    opf_format u_fmt (
        .byte0 (s_q.slots[0]),
        .byte1 (s_q.slots[1]),
        .fmt   (fmt),
        .value (fmt_value),
        .used  (fmt_used),
        .need  (fmt_need)
    );

    opf_fetch_ctl #(.ADDR_W(ADDR_W)) u_fctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .flush_addr (flush_addr),
        .take       (take),
        .addr_o     (mem_addr),
        .skip_o     (skip)
    );

    always_comb begin
        enough   = (s_q.cnt >= CNT_W'(fmt_need));
        op_valid = req_stb && !flush && enough;
        stall    = req_stb && !flush && !enough;
        op_data  = fmt_value;
        mem_req  = !flush && (s_q.cnt <= FILL_LIMIT);
        take     = mem_req && mem_valid;

        used_n   = op_valid ? fmt_used : 2'd0;
        slots_sh = s_q.slots >> {used_n, 3'b000};
        cnt_sh   = s_q.cnt - CNT_W'(used_n);
        wr0      = cnt_sh[IDX_W-1:0];
        wr1      = IDX_W'(cnt_sh + CNT_W'(1));

        s_d = s_q;
        if (flush) begin
            s_d.slots = '0;
            s_d.cnt   = '0;
        end else begin
            s_d.slots = slots_sh;
            s_d.cnt   = cnt_sh;
            if (take) begin
                if (skip) begin
                    s_d.slots[wr0] = mem_rdata[15:8];
                    s_d.cnt        = cnt_sh + CNT_W'(1);
                end else begin
                    s_d.slots[wr0] = mem_rdata[7:0];
                    s_d.slots[wr1] = mem_rdata[15:8];
                    s_d.cnt        = cnt_sh + CNT_W'(2);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R10
    buf_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(BUF_BYTES));

    // R8
    addr_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr[0] == 1'b0);

    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (s_q.cnt == '0));

    // R7
    wide_need_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && req_fmt[1]) |-> (s_q.cnt >= CNT_W'(2)));

    // R11
    no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_valid && !flush && !op_valid) |=> (s_q.cnt == $past(s_q.cnt)));

    // R5
    big_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && req_fmt == 2'd3 && !s_q.slots[0][7])
            |-> (op_data == {8'h00, s_q.slots[0]}));

    // R12
    flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!op_valid && !mem_req));
endmodule

// File: tb/sim_opf_prefetch.sv
module sim_opf_prefetch;
    import opf_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_valid = 1'b1;
    logic [15:0] mem_rdata;
    logic        req_stb = 1'b0;
    logic [1:0]  req_fmt = 2'd0;
    logic        flush = 1'b0;
    logic [15:0] flush_addr = '0;
    logic [15:0] op_data;
    logic        op_valid;
    logic        stall;

    logic [7:0] mem [0:255];
    logic [7:0] rd_ptr = 8'd0;
    int         n_tests = 0;
    int         n_fail = 0;
    logic [7:0] a0, a1;

    always #5 clk = ~clk;

    assign a0 = mem_addr[7:0];
    assign a1 = a0 + 8'd1;
    assign mem_rdata = {mem[a1], mem[a0]};

    opf_prefetch u0 (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata), .req_stb(req_stb),
        .req_fmt(req_fmt), .flush(flush), .flush_addr(flush_addr),
        .op_data(op_data), .op_valid(op_valid), .stall(stall)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_op(input logic [1:0] f, input string req);
        logic [7:0]  b0, b1;
        logic [15:0] exp;
        int          used;
        bit          done = 0;
        for (int k = 0; k < 50 && !done; k++) begin
            #1;
            if (op_valid) begin
                b0 = mem[rd_ptr];
                b1 = mem[rd_ptr + 8'd1];
                used = 1;
                case (f)
                    2'd0: exp = {{8{b0[7]}}, b0};
                    2'd1: exp = {8'h00, b0};
                    2'd2: begin exp = {b1, b0}; used = 2; end
                    default: begin
                        if (b0[7]) begin exp = {1'b0, b0[6:0], b1}; used = 2; end
                        else exp = {8'h00, b0};
                    end
                endcase
                check(req, {16'h0, op_data}, {16'h0, exp});
                rd_ptr = rd_ptr + 8'(used);
                done = 1;
                @(posedge clk);
                @(negedge clk);
                req_stb = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
        if (!done) begin
            check({req, " timeout"}, 32'd0, 32'd1);
            req_stb = 1'b0;
        end
    endtask

    task automatic get_op(input logic [1:0] f, input string req);
        req_fmt = f;
        req_stb = 1'b1;
        wait_op(f, req);
    endtask

    task automatic do_flush(input logic [15:0] a);
        flush = 1'b1;
        flush_addr = a;
        @(posedge clk);
        @(negedge clk);
        flush = 1'b0;
        rd_ptr = a[7:0];
    endtask

    task automatic t_reset;
        #1;
        check("R1 op_valid", {31'h0, op_valid}, 32'd0);
        check("R1 stall", {31'h0, stall}, 32'd0);
        check("R1 mem_req", {31'h0, mem_req}, 32'd1);
        check("R1 mem_addr", {16'h0, mem_addr}, 32'd0);
    endtask

    task automatic t_formats;
        get_op(2'd0, "R2 negative sbyte");
        get_op(2'd1, "R3 ubyte high bit");
        get_op(2'd0, "R2 positive sbyte");
        get_op(2'd2, "R4 word");
        get_op(2'd3, "R5 big short");
        get_op(2'd3, "R6 big long");
        get_op(2'd3, "R6 big max");
    endtask

    task automatic t_stall_word;
        mem_valid = 1'b0;
        do_flush(16'h0040);
        req_fmt = 2'd2;
        req_stb = 1'b1;
        for (int k = 0; k < 3; k++) begin
            #1;
            check("R7 word stall", {31'h0, stall}, 32'd1);
            check("R7 word not valid", {31'h0, op_valid}, 32'd0);
            check("R11 addr held", {16'h0, mem_addr}, 32'h40);
            @(negedge clk);
        end
        mem_valid = 1'b1;
        wait_op(2'd2, "R8 word after flush");
    endtask

    task automatic t_odd_short_big;
        mem_valid = 1'b0;
        do_flush(16'h0051);
        mem_valid = 1'b1;
        @(negedge clk);
        mem_valid = 1'b0;
        req_fmt = 2'd3;
        req_stb = 1'b1;
        for (int k = 0; k < 2; k++) begin
            #1;
            check("R7 short big stall", {31'h0, stall}, 32'd1);
            @(negedge clk);
        end
        mem_valid = 1'b1;
        wait_op(2'd3, "R9 odd flush big");
        get_op(2'd1, "R9 next byte");
    endtask

    task automatic t_fill_limit;
        do_flush(16'h0060);
        repeat (6) @(negedge clk);
        #1;
        check("R10 fetch stops when full", {31'h0, mem_req}, 32'd0);
        check("R10 addr after two words", {16'h0, mem_addr}, 32'h64);
        get_op(2'd1, "R10 byte 0");
        get_op(2'd2, "R10 bytes 1-2");
        get_op(2'd0, "R10 byte 3");
    endtask

    task automatic t_flush_priority;
        req_fmt = 2'd1;
        req_stb = 1'b1;
        flush = 1'b1;
        flush_addr = 16'h0030;
        #1;
        check("R12 no op in flush", {31'h0, op_valid}, 32'd0);
        check("R12 no fetch in flush", {31'h0, mem_req}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        flush = 1'b0;
        rd_ptr = 8'h30;
        wait_op(2'd1, "R12 first byte after flush");
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) & 255);
        mem[0] = 8'hF3; mem[1] = 8'h9C; mem[2] = 8'h42;
        mem[3] = 8'h34; mem[4] = 8'h12;
        mem[5] = 8'h7F; mem[6] = 8'h85; mem[7] = 8'h21;
        mem[8] = 8'hFF; mem[9] = 8'hFF;
        mem[8'h50] = 8'hAA; mem[8'h51] = 8'h05; mem[8'h52] = 8'hC8;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_formats();
        t_stall_word();
        t_odd_short_big();
        t_fill_limit();
        t_flush_priority();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule